// File: doc/BRIEF.md
# Three-Channel Timer-Counter with Watchdog Reset Routing

The block provides three independent 32-bit counting channels behind a simple 32-bit register port. All channels take a common count tick from one programmable prescaler. Each channel can also select an external tick input instead. A channel counts up or down, in either auto-reload or one-shot mode. It is started, stopped and reloaded through its run register. Whenever a channel reaches its terminal count it sets a status bit. The status bit, gated by a per-channel interrupt enable, drives that channel's interrupt line.

Any channel can also serve as a watchdog for one of four CPUs. A reset-arm register holds one enable bit per CPU and a global arm bit. A mapping register gives each CPU a 2-bit channel select. When the selected channel expires with its interrupt enabled and both arm bits set, that CPU's reset line pulses for one cycle. Software keeps the watchdog quiet by writing start-plus-reload to the run register before the count runs out.

Top module: `tmr_wdog_top`

## Requirements
- R1: After reset every register reads zero, and all interrupt and CPU reset outputs are low.
- R2: The divider field (bits 15:8 of offset 0x00) sets the prescaled tick to one every D clock cycles. D of 0 or 1 gives a tick every cycle.
- R3: A down-counting auto-reload channel counts one per tick. A tick at count zero sets its status bit (bit 2n of 0xFC) and loads the reload value.
- R4: An up-counting channel (control bit 1) counts from zero. A tick at count equal to the reload value sets status and, in auto-reload mode, returns the count to zero.
- R5: In one-shot mode (control bit 3) the expiry clears the channel's run-enable (run register bit 0 on read), and the count then holds.
- R6: Run register writes act as follows. Bit 1 stops the channel and wins over bit 0. Bit 0 starts it. Bit 2 loads the start value: the reload value when counting down, zero when counting up. Writing bits 0 and 2 together restarts the count as a keepalive.
- R7: With control bit 4 set, a channel counts only on cycles where the external tick input is high.
- R8: While the suspend bit (bit 4 of 0x00) is set, no channel changes its count, and registers still read and write.
- R9: Writing ones to 0xF4 sets interrupt enables, and writing ones to 0xF0 clears them. Zero bits have no effect. Both offsets read back the enables. The interrupt output of channel n is its status bit ANDed with its enable.
- R10: Writing a 1 to a status bit at 0xFC clears it, and a 0 leaves it. An expiry in the same cycle as the clear leaves the bit set.
- R11: In 0xE0 (CPU bits 3:0, global bit 6) and 0xE4 (2 bits per CPU), CPU k's reset pulses for one cycle, the cycle after its selected channel expires. It fires only when that channel's interrupt is enabled and both arm bits are set.
- R12: Writing zero to 0xE0 disarms every CPU reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high during a strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| ext_tick | input | 1 | External count tick for channels using the external source |
| irq | output | 3 | Per-channel interrupt lines |
| cpu_rst | output | 4 | Per-CPU watchdog reset pulses |

## Verification
The hardest case to reach is the same-cycle clash between a status clear and a fresh expiry. The stimulus forces it by loading a reload value of zero. A down-counting channel then expires on every tick, so each clear write falls in an expiry cycle. The watchdog path is exercised by counting cycles from the keepalive write to the expiry. This fixes exactly which cycle must carry the reset pulse. Each missing arm condition (interrupt enable, global bit, CPU bit, channel mapping) is then removed in turn, and the reset line is watched over a full period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic ext;
    logic oneshot;
    logic up;
  } chan_cfg_t;

  localparam logic [7:0] OFS_GLB     = 8'h00;
  localparam logic [7:0] OFS_CON     = 8'h10;
  localparam logic [7:0] OFS_RUN     = 8'h18;
  localparam logic [7:0] OFS_RLD     = 8'h20;
  localparam logic [7:0] OFS_CNT     = 8'h28;
  localparam logic [7:0] CH_STRIDE   = 8'h20;
  localparam logic [7:0] OFS_RST_EN  = 8'hE0;
  localparam logic [7:0] OFS_RST_MAP = 8'hE4;
  localparam logic [7:0] OFS_IEN_CLR = 8'hF0;
  localparam logic [7:0] OFS_IEN_SET = 8'hF4;
  localparam logic [7:0] OFS_STS     = 8'hFC;

  function automatic logic [7:0] ch_ofs(input logic [7:0] base, input int unsigned n);
    return base + 8'(n) * CH_STRIDE;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] div,
  input  logic            suspend,
  output logic            tick_o
);
  logic [DIVW-1:0] pc_q, pc_d, last;

  always_comb begin
    last   = (div == '0) ? '0 : div - 1'b1;
    tick_o = !suspend && (pc_q >= last);
    if (suspend)     pc_d = pc_q;
    else if (tick_o) pc_d = '0;
    else             pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // a tick with a divider above one is never followed directly by another
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div > 1) |=> (!tick_o || div <= 1));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_tick,
  input  logic          ext_tick,
  input  logic          suspend,
  input  chan_cfg_t     cfg,
  input  logic          run_wr,
  input  logic [2:0]    run_data,
  input  logic          rld_wr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] rld_o,
  output logic          en_o,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q, cnt_d, rld_q, rld_d, start_val;
  logic          en_q, en_d, src_tick, at_term;

  always_comb begin
    src_tick  = cfg.ext ? (ext_tick && !suspend) : pre_tick;
    at_term   = cfg.up ? (cnt_q == rld_q) : (cnt_q == '0);
    start_val = cfg.up ? '0 : rld_q;
    expire_o  = en_q && src_tick && !run_wr && at_term;

    rld_d = rld_wr ? wdata : rld_q;
    en_d  = en_q;
    cnt_d = cnt_q;
    if (run_wr) begin
      if (run_data[1])      en_d = 1'b0;
      else if (run_data[0]) en_d = 1'b1;
      if (run_data[2])      cnt_d = start_val;
    end else if (en_q && src_tick) begin
      if (at_term) begin
        if (cfg.oneshot) en_d = 1'b0;
        else             cnt_d = start_val;
      end else begin
        cnt_d = cfg.up ? cnt_q + 1'b1 : cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
      en_q  <= en_d;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign en_o  = en_q;

  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && cfg.oneshot) |=> !en_o);
  assert_down_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !cfg.up && !cfg.oneshot) |=> (cnt_o == $past(rld_o)));
  assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_wr && !src_tick) |=> $stable(cnt_o));
endmodule

// File: rtl/tmr_irq_rst.sv
module tmr_irq_rst #(
  parameter int NCH  = 3,
  parameter int NCPU = 4,
  parameter int SELW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       expire,
  input  logic [NCH-1:0]       ien_set,
  input  logic [NCH-1:0]       ien_clr,
  input  logic [NCH-1:0]       sts_clr,
  input  logic                 arm_wr,
  input  logic [NCPU-1:0]      arm_cpu_d,
  input  logic                 arm_glb_d,
  input  logic                 map_wr,
  input  logic [NCPU*SELW-1:0] map_d,
  output logic [NCH-1:0]       ien_o,
  output logic [NCH-1:0]       sts_o,
  output logic [NCH-1:0]       irq_o,
  output logic [NCPU-1:0]      arm_cpu_o,
  output logic                 arm_glb_o,
  output logic [NCPU*SELW-1:0] map_o,
  output logic [NCPU-1:0]      cpu_rst_o
);
  localparam int NSEL = 1 << SELW;

  logic [NCH-1:0]       ien_q, ien_d, sts_q, sts_d;
  logic [NCPU-1:0]      arm_q, arm_d, rst_q, rst_d;
  logic                 glb_q, glb_d;
  logic [NCPU*SELW-1:0] map_q, map_dn;
  logic [NSEL-1:0]      hit_w;

  always_comb begin
    hit_w = '0;
    hit_w[NCH-1:0] = expire & ien_q;
    ien_d  = (ien_q | ien_set) & ~ien_clr;
    sts_d  = (sts_q & ~sts_clr) | expire;
    arm_d  = arm_wr ? arm_cpu_d : arm_q;
    glb_d  = arm_wr ? arm_glb_d : glb_q;
    map_dn = map_wr ? map_d : map_q;
    for (int k = 0; k < NCPU; k++)
      rst_d[k] = glb_q && arm_q[k] && hit_w[map_q[k*SELW +: SELW]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      sts_q <= '0;
      arm_q <= '0;
      glb_q <= 1'b0;
      map_q <= '0;
      rst_q <= '0;
    end else begin
      ien_q <= ien_d;
      sts_q <= sts_d;
      arm_q <= arm_d;
      glb_q <= glb_d;
      map_q <= map_dn;
      rst_q <= rst_d;
    end
  end

  assign ien_o     = ien_q;
  assign sts_o     = sts_q;
  assign irq_o     = sts_q & ien_q;
  assign arm_cpu_o = arm_q;
  assign arm_glb_o = glb_q;
  assign map_o     = map_q;
  assign cpu_rst_o = rst_q;

  for (genvar i = 0; i < NCH; i++) begin : g_sts_chk
    assert_expiry_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] |=> sts_o[i]);
    assert_clear_works_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_clr[i] && !expire[i]) |=> !sts_o[i]);
  end

  for (genvar k = 0; k < NCPU; k++) begin : g_rst_chk
    assert_rst_armed_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rst_o[k] |-> $past(arm_glb_o && arm_cpu_o[k]));
  end
endmodule

// File: rtl/tmr_wdog_top.sv
module tmr_wdog_top
  import tmr_pkg::*;
#(
  parameter int NCH  = 3,
  parameter int NCPU = 4,
  parameter int CW   = 32,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic            ext_tick,
  output logic [NCH-1:0]  irq,
  output logic [NCPU-1:0] cpu_rst
);
  localparam int SELW = (NCH < 2) ? 1 : $clog2(NCH);

  logic [1:0]            rs_q;
  logic                  rst_n_s;
  logic                  wr;
  logic                  susp_q, susp_d;
  logic [DIVW-1:0]       div_q, div_d;
  logic                  pre_tick;
  chan_cfg_t             cfg_q [NCH];
  chan_cfg_t             cfg_d [NCH];
  logic [NCH-1:0]        con_wr, run_wr, rld_wr, ch_en, expire;
  logic [CW-1:0]         ch_cnt [NCH];
  logic [CW-1:0]         ch_rld [NCH];
  logic [NCH-1:0]        ien_set, ien_clr, sts_clr, ien, sts;
  logic [NCPU-1:0]       arm_cpu;
  logic                  arm_glb;
  logic [NCPU*SELW-1:0]  map;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  assign wr = bus_sel && bus_we;

  always_comb begin
    susp_d = susp_q;
    div_d  = div_q;
    if (wr && bus_addr == OFS_GLB) begin
      susp_d = bus_wdata[4];
      div_d  = bus_wdata[8 +: DIVW];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      susp_q <= 1'b0;
      div_q  <= '0;
    end else begin
      susp_q <= susp_d;
      div_q  <= div_d;
    end
  end

  tmr_prescaler #(.DIVW(DIVW)) i_presc (
    .clk(clk), .rst_n(rst_n_s), .div(div_q), .suspend(susp_q), .tick_o(pre_tick)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign con_wr[n] = wr && bus_addr == ch_ofs(OFS_CON, n);
    assign run_wr[n] = wr && bus_addr == ch_ofs(OFS_RUN, n);
    assign rld_wr[n] = wr && bus_addr == ch_ofs(OFS_RLD, n);

    always_comb begin
      cfg_d[n] = cfg_q[n];
      if (con_wr[n]) begin
        cfg_d[n].up      = bus_wdata[1];
        cfg_d[n].oneshot = bus_wdata[3];
        cfg_d[n].ext     = bus_wdata[4];
      end
    end

    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) cfg_q[n] <= '0;
      else          cfg_q[n] <= cfg_d[n];
    end

    tmr_channel #(.CW(CW)) i_ch (
      .clk(clk), .rst_n(rst_n_s), .pre_tick(pre_tick), .ext_tick(ext_tick),
      .suspend(susp_q), .cfg(cfg_q[n]), .run_wr(run_wr[n]),
      .run_data(bus_wdata[2:0]), .rld_wr(rld_wr[n]), .wdata(bus_wdata[CW-1:0]),
      .cnt_o(ch_cnt[n]), .rld_o(ch_rld[n]), .en_o(ch_en[n]), .expire_o(expire[n])
    );

    assign ien_set[n] = wr && bus_addr == OFS_IEN_SET && bus_wdata[2*n];
    assign ien_clr[n] = wr && bus_addr == OFS_IEN_CLR && bus_wdata[2*n];
    assign sts_clr[n] = wr && bus_addr == OFS_STS     && bus_wdata[2*n];

    assert_stop_wins_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
      (run_wr[n] && bus_wdata[1]) |=> !ch_en[n]);
  end

  tmr_irq_rst #(.NCH(NCH), .NCPU(NCPU), .SELW(SELW)) i_irq (
    .clk(clk), .rst_n(rst_n_s), .expire(expire),
    .ien_set(ien_set), .ien_clr(ien_clr), .sts_clr(sts_clr),
    .arm_wr(wr && bus_addr == OFS_RST_EN), .arm_cpu_d(bus_wdata[NCPU-1:0]),
    .arm_glb_d(bus_wdata[6]),
    .map_wr(wr && bus_addr == OFS_RST_MAP), .map_d(bus_wdata[NCPU*SELW-1:0]),
    .ien_o(ien), .sts_o(sts), .irq_o(irq),
    .arm_cpu_o(arm_cpu), .arm_glb_o(arm_glb), .map_o(map), .cpu_rst_o(cpu_rst)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_GLB: begin
        bus_rdata[4]         = susp_q;
        bus_rdata[8 +: DIVW] = div_q;
      end
      OFS_IEN_CLR, OFS_IEN_SET:
        for (int n = 0; n < NCH; n++) bus_rdata[2*n] = ien[n];
      OFS_STS:
        for (int n = 0; n < NCH; n++) bus_rdata[2*n] = sts[n];
      OFS_RST_EN: begin
        bus_rdata[NCPU-1:0] = arm_cpu;
        bus_rdata[6]        = arm_glb;
      end
      OFS_RST_MAP: bus_rdata[NCPU*SELW-1:0] = map;
      default:
        for (int n = 0; n < NCH; n++) begin
          if (bus_addr == ch_ofs(OFS_CON, n)) begin
            bus_rdata[1] = cfg_q[n].up;
            bus_rdata[3] = cfg_q[n].oneshot;
            bus_rdata[4] = cfg_q[n].ext;
          end
          if (bus_addr == ch_ofs(OFS_RUN, n)) bus_rdata[0] = ch_en[n];
          if (bus_addr == ch_ofs(OFS_RLD, n)) bus_rdata[CW-1:0] = ch_rld[n];
          if (bus_addr == ch_ofs(OFS_CNT, n)) bus_rdata[CW-1:0] = ch_cnt[n];
        end
    endcase
  end
endmodule

// File: tb/test_tmr_wdog_top.sv
module test_tmr_wdog_top;
  localparam time CLK_P = 8ns;
  localparam int  NV    = 44;

  logic        clk, rst_n, bus_sel, bus_we, ext_tick;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [2:0]  irq;
  logic [3:0]  cpu_rst, seen;
  int          checks, fails;
  bit          done;

  tmr_wdog_top i_tmr_wdog_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_tick(ext_tick), .irq(irq), .cpu_rst(cpu_rst)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // op[45:44] 0=write 1=read-compare 2=idle cycles, addr[43:36], data[35:4], req[3:0]
  localparam logic [45:0] VEC [NV] = '{
    {2'd0, 8'h20, 32'd3,    4'd3}, {2'd0, 8'h10, 32'd0,    4'd3},
    {2'd0, 8'h18, 32'd5,    4'd6}, {2'd1, 8'h28, 32'd3,    4'd6},
    {2'd1, 8'h18, 32'd1,    4'd6}, {2'd2, 8'h00, 32'd1,    4'd3},
    {2'd1, 8'h28, 32'd2,    4'd3}, {2'd2, 8'h00, 32'd2,    4'd3},
    {2'd1, 8'h28, 32'd0,    4'd3}, {2'd1, 8'hFC, 32'd0,    4'd3},
    {2'd2, 8'h00, 32'd1,    4'd3}, {2'd1, 8'h28, 32'd3,    4'd3},
    {2'd1, 8'hFC, 32'd1,    4'd3}, {2'd0, 8'hFC, 32'd0,    4'd10},
    {2'd1, 8'hFC, 32'd1,    4'd10},{2'd0, 8'hFC, 32'd1,    4'd10},
    {2'd1, 8'hFC, 32'd0,    4'd10},{2'd0, 8'h18, 32'd2,    4'd6},
    {2'd1, 8'h18, 32'd0,    4'd6}, {2'd2, 8'h00, 32'd3,    4'd6},
    {2'd1, 8'h28, 32'd1,    4'd6}, {2'd0, 8'h40, 32'd2,    4'd5},
    {2'd0, 8'h30, 32'h0A,   4'd5}, {2'd0, 8'h38, 32'd5,    4'd5},
    {2'd1, 8'h48, 32'd0,    4'd4}, {2'd2, 8'h00, 32'd2,    4'd4},
    {2'd1, 8'h48, 32'd2,    4'd4}, {2'd1, 8'h38, 32'd1,    4'd5},
    {2'd2, 8'h00, 32'd1,    4'd5}, {2'd1, 8'h48, 32'd2,    4'd5},
    {2'd1, 8'h38, 32'd0,    4'd5}, {2'd1, 8'hFC, 32'd4,    4'd5},
    {2'd2, 8'h00, 32'd2,    4'd5}, {2'd1, 8'h48, 32'd2,    4'd5},
    {2'd0, 8'hFC, 32'd4,    4'd10},{2'd1, 8'hFC, 32'd0,    4'd10},
    {2'd0, 8'h30, 32'd2,    4'd4}, {2'd0, 8'h38, 32'd5,    4'd4},
    {2'd2, 8'h00, 32'd3,    4'd4}, {2'd1, 8'h48, 32'd0,    4'd4},
    {2'd1, 8'hFC, 32'd4,    4'd4}, {2'd0, 8'h38, 32'd2,    4'd6},
    {2'd0, 8'hFC, 32'd4,    4'd10},{2'd1, 8'hFC, 32'd0,    4'd10}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic watch(input int n);
    seen = '0;
    repeat (n) begin @(posedge clk); #1; seen |= cpu_rst; end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] c1, c2;
    checks = 0; fails = 0; done = 1'b0; seen = '0;
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; ext_tick = 1'b0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rchk("R1 glb", 8'h00, 0);
    rchk("R1 run", 8'h18, 0);
    rchk("R1 cnt", 8'h28, 0);
    rchk("R1 ien", 8'hF4, 0);
    rchk("R1 sts", 8'hFC, 0);
    rchk("R1 arm", 8'hE0, 0);
    chk("R1 irq", {29'd0, irq}, 0);
    chk("R1 cpu_rst", {28'd0, cpu_rst}, 0);

    // table walk: R3 R4 R5 R6 R10
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [7:0]  a;
      logic [31:0] d;
      string       tag;
      op = VEC[i][45:44]; a = VEC[i][43:36]; d = VEC[i][35:4];
      tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
      case (op)
        2'd0: wr(a, d);
        2'd1: rchk(tag, a, d);
        default: idle(int'(d));
      endcase
    end

    // R2 divider of 4: exactly two ticks in any eight cycles
    wr(8'h00, 32'h0400);
    wr(8'h20, 1000);
    wr(8'h10, 0);
    wr(8'h18, 5);
    rd(8'h28, c1);
    idle(8);
    rd(8'h28, c2);
    chk("R2 ticks per 8 cycles", c1 - c2, 2);
    wr(8'h18, 2);
    wr(8'h00, 0);

    // R7 external source
    wr(8'h10, 32'h10);
    wr(8'h18, 5);
    idle(5);
    rchk("R7 no ext tick", 8'h28, 1000);
    ext_tick = 1'b1; idle(3); ext_tick = 1'b0;
    rchk("R7 three ext ticks", 8'h28, 997);

    // R8 suspend
    wr(8'h10, 0);
    wr(8'h18, 5);
    wr(8'h00, 32'h10);
    idle(5);
    rchk("R8 held", 8'h28, 999);
    rchk("R8 reg access", 8'h00, 32'h10);
    wr(8'h00, 0);
    idle(2);
    rchk("R8 resumed", 8'h28, 997);

    // R6 keepalive, stop priority, reload while stopped
    idle(7);
    rchk("R6 running", 8'h28, 990);
    wr(8'h18, 5);
    rchk("R6 keepalive", 8'h28, 1000);
    wr(8'h18, 3);
    rchk("R6 stop wins", 8'h18, 0);
    idle(3);
    rchk("R6 stopped holds", 8'h28, 1000);
    wr(8'h20, 50);
    wr(8'h18, 4);
    rchk("R6 reload only", 8'h28, 50);
    rchk("R6 reload no start", 8'h18, 0);

    // R9 interrupt enable set/clear
    wr(8'h20, 1);
    wr(8'hF4, 1);
    rchk("R9 ien set", 8'hF4, 1);
    rchk("R9 ien via clr offset", 8'hF0, 1);
    wr(8'h18, 5);
    idle(2);
    chk("R9 irq up", {29'd0, irq}, 3'b001);
    wr(8'hF0, 0);
    chk("R9 zero clr no effect", {29'd0, irq}, 3'b001);
    wr(8'hF0, 1);
    chk("R9 irq masked", {29'd0, irq}, 3'b000);
    rchk("R9 ien cleared", 8'hF4, 0);
    wr(8'h18, 2);
    wr(8'hFC, 1);

    // R10 clear collides with expiry
    wr(8'h20, 0);
    wr(8'h18, 5);
    idle(1);
    wr(8'hFC, 1);
    rchk("R10 expiry wins", 8'hFC, 1);
    wr(8'h18, 2);
    wr(8'hFC, 1);
    rchk("R10 cleared", 8'hFC, 0);

    // R11 watchdog reset timing and gating
    wr(8'h20, 2);
    wr(8'hF4, 1);
    wr(8'hE4, 0);
    wr(8'hE0, 32'h44);
    wr(8'h18, 5);
    idle(2);
    chk("R11 before expiry", {28'd0, cpu_rst}, 0);
    idle(1);
    chk("R11 pulse cpu2", {28'd0, cpu_rst}, 4'b0100);
    idle(1);
    chk("R11 one cycle", {28'd0, cpu_rst}, 0);
    wr(8'h18, 2);
    wr(8'hE0, 32'h04);
    wr(8'h18, 5);
    watch(6);
    chk("R11 no global arm", {28'd0, seen}, 0);
    wr(8'h18, 2);
    wr(8'hE0, 32'h41);
    wr(8'hE4, 1);
    wr(8'h18, 5);
    watch(6);
    chk("R11 mapped elsewhere", {28'd0, seen}, 0);
    wr(8'h18, 2);
    wr(8'hE4, 0);
    wr(8'hF0, 1);
    wr(8'h18, 5);
    watch(6);
    chk("R11 ien off", {28'd0, seen}, 0);
    wr(8'h18, 2);

    // R12 disarm all
    wr(8'hF4, 1);
    wr(8'hE0, 32'h4F);
    rchk("R12 armed readback", 8'hE0, 32'h4F);
    wr(8'hE0, 0);
    rchk("R12 disarmed readback", 8'hE0, 0);
    wr(8'h18, 5);
    watch(6);
    chk("R12 no reset", {28'd0, seen}, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule